// File: doc/BRIEF.md
# Register File with Deferred Possibly-Incorrect Flags

This block is an architectural register file in which every register carries one extra flag marking its value as possibly incorrect. When an instruction commits with a suspected corruption, the block does not report it straight away. Instead it writes the result and raises the flag on the destination register. The suspicion then stays with the value until something consumes it.

A value that is overwritten before anyone reads it is dynamically dead, so its flag is dropped without any report. This removes false detected-error reports for results that never affect the program.

An elaboration parameter sets where the report is raised. In read mode, an enabled read of a flagged register raises the error. In store mode, reads only pass the flag along, and the error is raised when a store commits whose data register is flagged. The error output is a registered pulse that carries the offending register index.

Top module: `pirf_top`

## Requirements
- R1: A commit write stores its data in the addressed register and copies its incoming flag into that register's flag, so a write with a clear flag clears a flag that was set before.
- R2: A commit write with its flag set raises no error of its own, in the cycle after the write or later.
- R3: In read mode (`STORE_MODE`=0), an enabled read of a flagged register makes `err_pulse` high in the next cycle, with `err_reg` equal to that register's index.
- R4: A flagged register that is overwritten with a clean write before any enabled read of it never causes an error.
- R5: In store mode (`STORE_MODE`=1), a store commit (`sc_en`) naming a flagged register makes `err_pulse` high in the next cycle with that index. Enabled reads of flagged registers raise no error but still show the flag on their `*_pi` output.
- R6: A read of the register being written in the same cycle returns the new data and the new flag (write-through). A store commit naming that register uses the new flag.
- R7: In read mode, if both read ports hit flagged registers in the same cycle, `err_reg` reports the index on port A.
- R8: `err_pulse` is high for exactly the cycles that follow a triggering cycle, and is low after any cycle with no trigger.
- R9: Reset clears every register to zero, every flag, and `err_pulse`.
- R10: In read mode, store commits have no effect on `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_en | input | 1 | Commit write enable |
| cw_idx | input | 4 | Commit write register index |
| cw_data | input | 32 | Commit write data |
| cw_pi | input | 1 | Possibly-incorrect flag of the committing instruction |
| ra_en | input | 1 | Read port A is consumed by an instruction |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | 32 | Read port A data (combinational) |
| ra_pi | output | 1 | Read port A flag (combinational) |
| rb_en | input | 1 | Read port B is consumed by an instruction |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | 32 | Read port B data (combinational) |
| rb_pi | output | 1 | Read port B flag (combinational) |
| sc_en | input | 1 | Store commit valid |
| sc_idx | input | 4 | Register that supplied the store data |
| err_pulse | output | 1 | Registered error pulse |
| err_reg | output | 4 | Index of the offending register, valid with err_pulse |

## Verification
Read data and read flags are combinational. The bench samples them in the same cycle the index is driven, just before the rising edge, and expects write-through values whenever the write targets the same register. The error pulse is registered one cycle behind its trigger, so the bench stores the expected error computed in the triggering cycle and compares it at the following falling edge. Two instances, one per mode, receive the same stimulus, so the mode difference is visible on every cycle.

// File: rtl/pirf_pkg.sv
package pirf_pkg;

    // Where a deferred corruption is finally reported
    typedef enum logic {
        REPORT_ON_READ  = 1'b0,
        REPORT_ON_STORE = 1'b1
    } report_mode_e;

endpackage

// File: rtl/pirf_store.sv
module pirf_store #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_pi,
    output logic [DW-1:0] data_q [NREG],
    output logic [NREG-1:0] pi_q
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] data;
        logic [NREG-1:0]         pi;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data[wr_idx] = wr_data;
            st_d.pi[wr_idx]   = wr_pi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign data_q[g] = st_q.data[g];
    end
    assign pi_q = st_q.pi;

endmodule

// File: rtl/pirf_rdport.sv
module pirf_rdport #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [DW-1:0]   data_q [NREG],
    input  logic [NREG-1:0] pi_q,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            wr_pi,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            rd_pi
);

    logic bypass;

    always_comb begin
        bypass  = wr_en && (wr_idx == rd_idx);
        rd_data = bypass ? wr_data : data_q[rd_idx];
        rd_pi   = bypass ? wr_pi   : pi_q[rd_idx];
    end

endmodule

// File: rtl/pirf_errgen.sv
module pirf_errgen
    import pirf_pkg::*;
#(
    parameter int           NREG = 16,
    parameter report_mode_e MODE = REPORT_ON_READ,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] pi_q,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic            wr_pi,
    input  logic            ra_en,
    input  logic [IW-1:0]   ra_idx,
    input  logic            ra_pi,
    input  logic            rb_en,
    input  logic [IW-1:0]   rb_idx,
    input  logic            rb_pi,
    input  logic            sc_en,
    input  logic [IW-1:0]   sc_idx,
    output logic            err_pulse,
    output logic [IW-1:0]   err_reg
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } err_t;

    err_t err_d, err_q;
    logic sc_pi;
    logic hit_a, hit_b, hit_s;

    always_comb begin
        sc_pi = (wr_en && (wr_idx == sc_idx)) ? wr_pi : pi_q[sc_idx];
        hit_a = ra_en && ra_pi;
        hit_b = rb_en && rb_pi;
        hit_s = sc_en && sc_pi;
        err_d = '0;
        if (MODE == REPORT_ON_STORE) begin
            if (hit_s) err_d = '{vld: 1'b1, idx: sc_idx};
        end else begin
            if (hit_a)      err_d = '{vld: 1'b1, idx: ra_idx};
            else if (hit_b) err_d = '{vld: 1'b1, idx: rb_idx};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_pulse = err_q.vld;
    assign err_reg   = err_q.idx;

endmodule

// File: rtl/pirf_top.sv
module pirf_top
    import pirf_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int DW         = 32,
    parameter bit STORE_MODE = 1'b0,
    localparam int IW        = $clog2(NREG),
    localparam int NRD       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cw_en,
    input  logic [IW-1:0] cw_idx,
    input  logic [DW-1:0] cw_data,
    input  logic          cw_pi,
    input  logic          ra_en,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    output logic          ra_pi,
    input  logic          rb_en,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    output logic          rb_pi,
    input  logic          sc_en,
    input  logic [IW-1:0] sc_idx,
    output logic          err_pulse,
    output logic [IW-1:0] err_reg
);

    localparam report_mode_e MODE = STORE_MODE ? REPORT_ON_STORE : REPORT_ON_READ;

    logic [DW-1:0]   data_q [NREG];
    logic [NREG-1:0] pi_q;
    logic [IW-1:0]   p_idx  [NRD];
    logic [DW-1:0]   p_data [NRD];
    logic            p_pi   [NRD];

    pirf_store #(.NREG(NREG), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cw_en), .wr_idx(cw_idx), .wr_data(cw_data), .wr_pi(cw_pi),
        .data_q(data_q), .pi_q(pi_q)
    );

    assign p_idx[0] = ra_idx;
    assign p_idx[1] = rb_idx;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        pirf_rdport #(.NREG(NREG), .DW(DW)) u_rd (
            .data_q(data_q), .pi_q(pi_q),
            .wr_en(cw_en), .wr_idx(cw_idx), .wr_data(cw_data), .wr_pi(cw_pi),
            .rd_idx(p_idx[p]), .rd_data(p_data[p]), .rd_pi(p_pi[p])
        );
    end

    assign ra_data = p_data[0];
    assign ra_pi   = p_pi[0];
    assign rb_data = p_data[1];
    assign rb_pi   = p_pi[1];

    pirf_errgen #(.NREG(NREG), .MODE(MODE)) u_err (
        .clk(clk), .rst_n(rst_n), .pi_q(pi_q),
        .wr_en(cw_en), .wr_idx(cw_idx), .wr_pi(cw_pi),
        .ra_en(ra_en), .ra_idx(ra_idx), .ra_pi(p_pi[0]),
        .rb_en(rb_en), .rb_idx(rb_idx), .rb_pi(p_pi[1]),
        .sc_en(sc_en), .sc_idx(sc_idx),
        .err_pulse(err_pulse), .err_reg(err_reg)
    );

endmodule

// File: rtl/pirf_chk.sv
module pirf_chk #(
    parameter int NREG       = 16,
    parameter int DW         = 32,
    parameter bit STORE_MODE = 1'b0,
    localparam int IW        = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cw_en,
    input logic [IW-1:0] cw_idx,
    input logic [DW-1:0] cw_data,
    input logic          cw_pi,
    input logic          ra_en,
    input logic [IW-1:0] ra_idx,
    input logic [DW-1:0] ra_data,
    input logic          ra_pi,
    input logic          rb_en,
    input logic          rb_pi,
    input logic [IW-1:0] rb_idx,
    input logic          sc_en,
    input logic          err_pulse,
    input logic [IW-1:0] err_reg
);

    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && cw_idx == ra_idx) |-> (ra_data == cw_data && ra_pi == cw_pi)); // R6

    AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && cw_pi && !(ra_en && ra_idx == cw_idx)) |=>
        ((ra_idx == $past(cw_idx) && !(cw_en && cw_idx == ra_idx)) -> ra_pi)); // R1

    generate
        if (STORE_MODE) begin : g_st
            AST_NO_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
                !sc_en |=> !err_pulse); // R5
        end else begin : g_rd
            AST_READ_ERR_A: assert property (@(posedge clk) disable iff (!rst_n)
                (ra_en && ra_pi) |=> (err_pulse && err_reg == $past(ra_idx))); // R7
            AST_READ_ERR_B: assert property (@(posedge clk) disable iff (!rst_n)
                (!(ra_en && ra_pi) && rb_en && rb_pi) |=>
                (err_pulse && err_reg == $past(rb_idx))); // R3
            AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (!(ra_en && ra_pi) && !(rb_en && rb_pi)) |=> !err_pulse); // R8
        end
    endgenerate

endmodule

bind pirf_top pirf_chk #(.NREG(NREG), .DW(DW), .STORE_MODE(STORE_MODE)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data), .cw_pi(cw_pi),
    .ra_en(ra_en), .ra_idx(ra_idx), .ra_data(ra_data), .ra_pi(ra_pi),
    .rb_en(rb_en), .rb_pi(rb_pi), .rb_idx(rb_idx),
    .sc_en(sc_en), .err_pulse(err_pulse), .err_reg(err_reg)
);

// File: tb/pirf_top_tb.sv
module pirf_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int IW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cw_en = 0, cw_pi = 0, ra_en = 0, rb_en = 0, sc_en = 0;
    logic [IW-1:0] cw_idx = 0, ra_idx = 0, rb_idx = 0, sc_idx = 0;
    logic [DW-1:0] cw_data = 0;
    logic [DW-1:0] ra_data, rb_data, sa_data, sb_data;
    logic ra_pi, rb_pi, sa_pi, sb_pi;
    logic err_pulse, s_err_pulse;
    logic [IW-1:0] err_reg, s_err_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m_data [NREG];
    logic          m_pi   [NREG];
    logic          exp_r_v = 0, exp_s_v = 0;
    logic [IW-1:0] exp_r_i = 0, exp_s_i = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pirf_top #(.STORE_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data), .cw_pi(cw_pi),
        .ra_en(ra_en), .ra_idx(ra_idx), .ra_data(ra_data), .ra_pi(ra_pi),
        .rb_en(rb_en), .rb_idx(rb_idx), .rb_data(rb_data), .rb_pi(rb_pi),
        .sc_en(sc_en), .sc_idx(sc_idx), .err_pulse(err_pulse), .err_reg(err_reg));

    pirf_top #(.STORE_MODE(1'b1)) u_dut_st (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data), .cw_pi(cw_pi),
        .ra_en(ra_en), .ra_idx(ra_idx), .ra_data(sa_data), .ra_pi(sa_pi),
        .rb_en(rb_en), .rb_idx(rb_idx), .rb_data(sb_data), .rb_pi(sb_pi),
        .sc_en(sc_en), .sc_idx(sc_idx), .err_pulse(s_err_pulse), .err_reg(s_err_reg));

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] mdata(input logic [IW-1:0] i);
        return (cw_en && cw_idx == i) ? cw_data : m_data[i];
    endfunction
    function automatic logic mpi(input logic [IW-1:0] i);
        return (cw_en && cw_idx == i) ? cw_pi : m_pi[i];
    endfunction

    // Called at a falling edge after inputs are set: check reads, predict errors, update model
    task automatic step(input string tag);
        logic pa, pb, ps;
        #1;
        pa = mpi(ra_idx); pb = mpi(rb_idx); ps = mpi(sc_idx);
        chk(ra_data == mdata(ra_idx) && sa_data == mdata(ra_idx), {tag, " R1 R6 port A data"}, ra_data, mdata(ra_idx));
        chk(rb_data == mdata(rb_idx) && sb_data == mdata(rb_idx), {tag, " R1 R6 port B data"}, rb_data, mdata(rb_idx));
        chk(ra_pi == pa && rb_pi == pb && sa_pi == pa && sb_pi == pb, {tag, " R1 R5 flags"}, {ra_pi, rb_pi}, {pa, pb});
        exp_r_v = (ra_en && pa) || (rb_en && pb);
        exp_r_i = (ra_en && pa) ? ra_idx : rb_idx;
        exp_s_v = sc_en && ps;
        exp_s_i = sc_idx;
        if (cw_en) begin m_data[cw_idx] = cw_data; m_pi[cw_idx] = cw_pi; end
        @(negedge clk);
        chk(err_pulse == exp_r_v, {tag, " R3 R8 R10 read-mode pulse"}, err_pulse, exp_r_v);
        if (exp_r_v) chk(err_reg == exp_r_i, {tag, " R3 R7 read-mode index"}, err_reg, exp_r_i);
        chk(s_err_pulse == exp_s_v, {tag, " R5 R8 store-mode pulse"}, s_err_pulse, exp_s_v);
        if (exp_s_v) chk(s_err_reg == exp_s_i, {tag, " R5 store-mode index"}, s_err_reg, exp_s_i);
    endtask

    task automatic drive(input logic w, input logic [IW-1:0] wi, input logic [DW-1:0] wd, input logic wp,
                         input logic ae, input logic [IW-1:0] ai, input logic be, input logic [IW-1:0] bi,
                         input logic se, input logic [IW-1:0] si, input string tag);
        cw_en = w; cw_idx = wi; cw_data = wd; cw_pi = wp;
        ra_en = ae; ra_idx = ai; rb_en = be; rb_idx = bi; sc_en = se; sc_idx = si;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int dummy;
        seed = 32'h5eed_0123;
        dummy = $urandom(seed);
        for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_pi[i] = 1'b0; end
        repeat (3) @(negedge clk);
        // R9: reset state
        for (int i = 0; i < NREG; i++) begin
            ra_idx = i[IW-1:0]; #1;
            chk(ra_data == 0 && ra_pi == 0 && sa_data == 0, "R9 reset contents", {ra_pi, ra_data}, 0);
        end
        chk(err_pulse == 0 && s_err_pulse == 0, "R9 reset pulse", {err_pulse, s_err_pulse}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: flagged write raises nothing itself
        drive(1, 5, 32'hAAAA_0005, 1, 0, 0, 0, 0, 0, 0, "R2 flagged write");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle after");
        // R4: overwrite clean before read, then read
        drive(1, 5, 32'hBBBB_0005, 0, 0, 0, 0, 0, 0, 0, "R4 clean overwrite");
        drive(0, 0, 0, 0, 1, 5, 0, 0, 1, 5, "R4 dead value read");
        // R3: flagged then read on port B
        drive(1, 7, 32'h7777, 1, 0, 0, 0, 0, 0, 0, "R3 set flag");
        drive(0, 0, 0, 0, 0, 0, 1, 7, 0, 0, "R3 port B read");
        // R7: both ports flagged
        drive(1, 9, 32'h9999, 1, 0, 0, 0, 0, 0, 0, "R7 set second flag");
        drive(0, 0, 0, 0, 1, 9, 1, 7, 0, 0, "R7 both flagged");
        // R6: write-through of flag and data, store uses new flag
        drive(1, 3, 32'h3333, 1, 1, 3, 0, 0, 1, 3, "R6 bypass set");
        drive(1, 7, 32'h0707, 0, 0, 0, 1, 7, 1, 7, "R6 bypass clear");
        // R5 / R10: store commit of flagged register, read not enabled
        drive(0, 0, 0, 0, 0, 9, 0, 0, 1, 9, "R5 R10 store of flagged");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [IW-1:0] narrow;
            narrow = ($urandom % 4 == 0) ? IW'($urandom % 16) : IW'($urandom % 4);
            drive($urandom % 2 == 0, narrow, $urandom, $urandom % 3 == 0,
                  $urandom % 2 == 0, IW'($urandom % 4), $urandom % 2 == 0, IW'($urandom % 4),
                  $urandom % 3 == 0, IW'($urandom % 4), "random");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule